// File: doc/BRIEF.md
# Three-Channel Compare-Match Timer Bank

This block holds a set of independent up-counting timers, three by default, each with an 18-bit counter, a compare register and a small control word. A timer advances only in a cycle where the shared `tick` input is high. A separate divider elsewhere on the chip produces that enable pulse. When a running timer is found equal to its compare value on a tick, the channel records a match. What the counter does next depends on the channel's mode. In one-shot mode the timer stops. In interval mode the counter goes back to zero. In free-run mode it keeps counting and wraps around.

Every match sets that channel's sticky status bit. Software clears the bit by writing a one to it. The channel's interrupt line is high while both its status bit and its interrupt-enable bit are set. Software reaches the block through a flat register port: a single-cycle write strobe with address and data, and a read port whose data follows the read address combinationally.

Top module: `cmp_timer_bank`

## Requirements
- R1: After reset every counter, compare value, control word and status bit is zero, all timers are stopped and every `irq` bit is low.
- R2: The address is split into two fields. Bits [ADDR_W-1:2] select the channel and bits [1:0] select the register. Register 0 is control, with mode in bits [3:2], interrupt enable in bit 1 and run in bit 0. Register 1 is compare, read/write. Register 2 is the counter, read-only, and writes to it are ignored. The channel index NUM_CH with register 0 is the status register, where bit i belongs to channel i. Every other address reads as zero.
- R3: A counter changes only in a cycle where `tick` is high and its channel is running. In every other cycle it holds its value.
- R4: A control write that sets run while the channel is stopped clears the counter to zero. A control write to a channel takes priority over a tick in the same cycle: that cycle produces no count and no match.
- R5: A match occurs on a tick when the running counter equals the compare value. The status bit is set at that same clock edge.
- R6: In one-shot mode (mode 0), a match clears the run bit and the counter holds the matched value.
- R7: In interval mode (mode 1), a match reloads the counter to zero and the timer keeps running, so one period is compare+1 ticks.
- R8: In free-run mode (modes 2 and 3), a match does not disturb counting. The counter wraps from its all-ones value to zero and matches again 2^CNT_W ticks later.
- R9: Status bits are sticky and are cleared only by writing a one to them. If a match and a clear of the same bit fall in one cycle, the bit ends up set.
- R10: `irq[i]` is high exactly while channel i's status bit and interrupt-enable bit are both set.
- R11: A compare write takes effect from the very next tick, even while the timer runs.
- R12: Channels are independent: no write to, or match on, one channel changes another channel's counter, control word or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count enable pulse |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | CNT_W | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | CNT_W | Read data, combinational from rdAddr |
| irq | output | NUM_CH | Interrupt per channel |

## Verification
The bench uses three channels with CNT_W set to 10. The narrow counter brings the free-run wrap within reach: a full lap takes 1024 ticks, where the default width would need over a quarter million. The three channels are exercised in different modes at the same time on the shared tick. This makes crosstalk between channels visible, and it lets the bench line up same-cycle collisions: a match with a status clear, and a tick with a start write.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_RELOAD = 2'd1,
    MODE_FREE   = 2'd2,
    MODE_FREE2  = 2'd3
  } tmrMode_e;

  // write strobes from the register decoder to one counter channel
  typedef struct packed {
    logic wrCtrl;
    logic wrCmp;
  } chStrobe_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CMP  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;

endpackage

// File: rtl/cmp_timer_datapath.sv
module cmp_timer_datapath
  import cmp_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 18
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             tick,
  input  chStrobe_t [NUM_CH-1:0]           strobes,
  input  logic [CNT_W-1:0]                 wrData,
  output logic [NUM_CH-1:0]                hitVec,
  output logic [NUM_CH-1:0]                runVec,
  output logic [NUM_CH-1:0][1:0]           modeVec,
  output logic [NUM_CH-1:0][CNT_W-1:0]     cntVec,
  output logic [NUM_CH-1:0][CNT_W-1:0]     cmpVec
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] cmpQ;
    logic [1:0]       modeQ;
    logic             runQ;
    logic             hit;

    // a control write in the same cycle suppresses counting and matching
    assign hit = tick && runQ && !strobes[i].wrCtrl && (cntQ == cmpQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ  <= '0;
        cmpQ  <= '0;
        modeQ <= 2'd0;
        runQ  <= 1'b0;
      end else begin
        if (strobes[i].wrCmp) cmpQ <= wrData;
        if (strobes[i].wrCtrl) begin
          modeQ <= wrData[3:2];
          runQ  <= wrData[0];
          if (wrData[0] && !runQ) cntQ <= '0;
        end else if (tick && runQ) begin
          if (hit) begin
            case (tmrMode_e'(modeQ))
              MODE_ONCE:   runQ <= 1'b0;
              MODE_RELOAD: cntQ <= '0;
              default:     cntQ <= cntQ + 1'b1;
            endcase
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
      end
    end

    assign hitVec[i]  = hit;
    assign runVec[i]  = runQ;
    assign modeVec[i] = modeQ;
    assign cntVec[i]  = cntQ;
    assign cmpVec[i]  = cmpQ;
  end

endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 18,
  parameter int ADDR_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [NUM_CH-1:0]                clrBits,
  input  logic                             ienBit,
  input  logic [ADDR_W-1:0]                rdAddr,
  input  logic [NUM_CH-1:0]                hitVec,
  input  logic [NUM_CH-1:0]                runVec,
  input  logic [NUM_CH-1:0][1:0]           modeVec,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     cntVec,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     cmpVec,
  output chStrobe_t [NUM_CH-1:0]           strobes,
  output logic [CNT_W-1:0]                 rdData,
  output logic [NUM_CH-1:0]                irq
);

  localparam int CH_W = ADDR_W - 2;

  logic [CH_W-1:0]   wrCh;
  logic [1:0]        wrReg;
  logic [CH_W-1:0]   rdCh;
  logic [1:0]        rdReg;
  logic              statWr;
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] ienQ;

  assign wrCh   = wrAddr[ADDR_W-1:2];
  assign wrReg  = wrAddr[1:0];
  assign rdCh   = rdAddr[ADDR_W-1:2];
  assign rdReg  = rdAddr[1:0];
  assign statWr = wrEn && (wrCh == CH_W'(NUM_CH)) && (wrReg == REG_CTRL);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      strobes[i].wrCtrl = wrEn && (wrCh == CH_W'(i)) && (wrReg == REG_CTRL);
      strobes[i].wrCmp  = wrEn && (wrCh == CH_W'(i)) && (wrReg == REG_CMP);
    end
  end

  // match set outranks a write-one clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      ienQ    <= '0;
    end else begin
      statusQ <= (statusQ & ~(statWr ? clrBits : '0)) | hitVec;
      for (int i = 0; i < NUM_CH; i++) begin
        if (strobes[i].wrCtrl) ienQ[i] <= ienBit;
      end
    end
  end

  assign irq = statusQ & ienQ;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rdCh == CH_W'(i)) begin
        case (rdReg)
          REG_CTRL: rdData[3:0] = {modeVec[i], ienQ[i], runVec[i]};
          REG_CMP:  rdData = cmpVec[i];
          REG_CNT:  rdData = cntVec[i];
          default:  rdData = '0;
        endcase
      end
    end
    if (rdCh == CH_W'(NUM_CH) && rdReg == REG_CTRL) rdData[NUM_CH-1:0] = statusQ;
  end

endmodule

// File: rtl/cmp_timer_bank.sv
module cmp_timer_bank
  import cmp_timer_pkg::*;
#(
  parameter  int NUM_CH = 3,
  parameter  int CNT_W  = 18,
  localparam int ADDR_W = 2 + $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] irq
);

  chStrobe_t [NUM_CH-1:0]         strobes;
  logic [NUM_CH-1:0]              hitVec;
  logic [NUM_CH-1:0]              runVec;
  logic [NUM_CH-1:0][1:0]         modeVec;
  logic [NUM_CH-1:0][CNT_W-1:0]   cntVec;
  logic [NUM_CH-1:0][CNT_W-1:0]   cmpVec;

  cmp_timer_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .clrBits(wrData[NUM_CH-1:0]), .ienBit(wrData[1]), .rdAddr(rdAddr),
    .hitVec(hitVec), .runVec(runVec), .modeVec(modeVec),
    .cntVec(cntVec), .cmpVec(cmpVec), .strobes(strobes),
    .rdData(rdData), .irq(irq)
  );

  cmp_timer_datapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strobes(strobes), .wrData(wrData),
    .hitVec(hitVec), .runVec(runVec), .modeVec(modeVec),
    .cntVec(cntVec), .cmpVec(cmpVec)
  );

endmodule

// File: rtl/cmp_timer_checker.sv
module cmp_timer_checker
  import cmp_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 18
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         tick,
  input logic                         wrEn,
  input logic                         startBit,
  input chStrobe_t [NUM_CH-1:0]       strobes,
  input logic [NUM_CH-1:0]            hitVec,
  input logic [NUM_CH-1:0]            runVec,
  input logic [NUM_CH-1:0][1:0]       modeVec,
  input logic [NUM_CH-1:0][CNT_W-1:0] cntVec,
  input logic [NUM_CH-1:0]            irq
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R3: no tick means the counter holds
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (runVec[i] && !tick && !strobes[i].wrCtrl) |=> $stable(cntVec[i]));

    // R3: a tick without a match steps the counter by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
      (runVec[i] && tick && !strobes[i].wrCtrl && !hitVec[i])
      |=> (cntVec[i] == CNT_W'($past(cntVec[i]) + 1'b1)));

    // R4: starting a stopped timer zeroes it
    p_start_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[i].wrCtrl && startBit && !runVec[i]) |=> (cntVec[i] == '0));

    // R6: one-shot match stops the timer and keeps the count
    p_once_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
      (hitVec[i] && modeVec[i] == 2'd0) |=> (!runVec[i] && $stable(cntVec[i])));

    // R7: interval match reloads zero and keeps running
    p_reload_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
      (hitVec[i] && modeVec[i] == 2'd1) |=> (runVec[i] && cntVec[i] == '0));

    // R9: a raised interrupt stays up while nothing is written
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
      (irq[i] && !wrEn) |=> irq[i]);
  end

endmodule

bind cmp_timer_bank cmp_timer_checker #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .startBit(wrData[0]),
  .strobes(strobes), .hitVec(hitVec), .runVec(runVec), .modeVec(modeVec),
  .cntVec(cntVec), .irq(irq)
);

// File: tb/cmp_timer_bank_test.sv
`timescale 1ns/1ps
module cmp_timer_bank_test;

  localparam int NCH  = 3;
  localparam int CW   = 10;
  localparam int AW   = 4;
  localparam int STAT = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [CW-1:0] rdData;
  logic [NCH-1:0] irq;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  cmp_timer_bank #(.NUM_CH(NCH), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = CW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rdAddr = AW'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic tickN(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    int v;
    rd(0, v);    chk("R1 ctrl0", v, 0);
    rd(2, v);    chk("R1 cnt0", v, 0);
    rd(9, v);    chk("R1 cmp2", v, 0);
    rd(STAT, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_oneshot;
    int v;
    wr(1, 5);
    wr(0, 3);
    tickN(5);
    rd(2, v);    chk("R3 cnt0 after 5 ticks", v, 5);
    rd(STAT, v); chk("R5 no match yet", v, 0);
    tickN(1);
    rd(STAT, v); chk("R5 status0 set", v, 1);
    chk("R10 irq0", int'(irq), 1);
    rd(0, v);    chk("R6 run cleared", v, 2);
    tickN(3);
    rd(2, v);    chk("R6 count held", v, 5);
    wr(STAT, 1);
    rd(STAT, v); chk("R9 cleared", v, 0);
    chk("R9 irq low", int'(irq), 0);
  endtask

  task automatic t_interval;
    int v;
    wr(5, 3);
    wr(4, 7);
    tickN(4);
    rd(STAT, v); chk("R7 status1", v, 2);
    rd(6, v);    chk("R7 reload zero", v, 0);
    chk("R10 irq1", int'(irq), 2);
    rd(2, v);    chk("R12 ch0 untouched", v, 5);
    tickN(2);
    rd(6, v);    chk("R7 keeps running", v, 2);
    wr(STAT, 2);
    wr(5, 2);
    tickN(1);
    rd(STAT, v); chk("R11 new compare hit", v, 2);
    rd(6, v);    chk("R11 reload", v, 0);
    tickN(1);
    repeat (10) @(negedge clk);
    rd(6, v);    chk("R3 hold without tick", v, 1);
    wr(6, 100);
    rd(6, v);    chk("R2 counter write ignored", v, 1);
    rd(5, v);    chk("R2 compare readback", v, 2);
    rd(3, v);    chk("R2 unmapped reads zero", v, 0);
    wr(4, 2);
    rd(4, v);    chk("R2 ctrl readback stopped", v, 2);
  endtask

  task automatic t_freerun;
    int v;
    wr(STAT, 7);
    wr(9, 4);
    wr(8, 9);
    tickN(5);
    rd(STAT, v); chk("R8 status2", v, 4);
    chk("R10 irq2 masked", int'(irq), 0);
    rd(10, v);   chk("R8 counts through", v, 5);
    wr(STAT, 4);
    tickN(1023);
    rd(10, v);   chk("R8 wrapped", v, 4);
    rd(STAT, v); chk("R8 no early match", v, 0);
    tickN(1);
    rd(STAT, v); chk("R8 match after lap", v, 4);
    wr(8, 11);
    chk("R10 irq2 enabled", int'(irq), 4);
    rd(10, v);   chk("R4 no clear when running", v, 5);
    rd(6, v);    chk("R12 ch1 stopped held", v, 1);
  endtask

  task automatic t_collide;
    int v;
    wr(8, 0);
    wr(STAT, 7);
    wr(1, 1);
    wr(0, 3);
    rd(2, v);    chk("R4 start clears", v, 0);
    tickN(1);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; wrAddr = AW'(STAT); wrData = CW'(1);
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    rd(STAT, v); chk("R9 set beats clear", v, 1);
    chk("R10 irq0 after collide", int'(irq), 1);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; wrAddr = AW'(0); wrData = CW'(3);
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    rd(2, v);    chk("R4 write beats tick", v, 0);
    tickN(1);
    rd(2, v);    chk("R4 counts after start", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_oneshot();
    t_interval();
    t_freerun();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule